// File: doc/BRIEF.md
# Sync-Referenced Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display. Both of its position counters read zero on the first cycle of the sync pulse, and every programmed edge (sync end, border window, display window, period end) is a count from that sync edge. The horizontal compare points carry fixed offsets that cover the latency of a downstream pixel pipeline. The period value is taken with its two low bits cleared and the window values with bit 0 cleared.

Software programs twelve timing values and one control word through a simple write port. The timing values go into shadow copies. These move into the working set only at a frame boundary, or at any time while output is disabled, so a frame never changes shape partway through. The control word takes effect on the next cycle. It holds the output enable and the two sync polarities. Writing zero to it stops the raster and blanks the display.

The outputs are a horizontal and a vertical sync, a border-colour window, a display-enable window, and one-cycle strobes at the start of each line and each frame. Fetching pixel data and looking up colours are left to other blocks.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, with the control word at zero, hsync, vsync, border_en, display_en, line_stb and frame_stb are all low.
- R2: The write map is a 4-bit address. Horizontal values are at 0 (period), 1 (sync width), 2 (border start), 3 (border end), 4 (display start) and 5 (display end). Vertical values follow the same order at 8 to 13, and the control word is at 15. Each timing value keeps the low field-width bits of wr_data (12 horizontal, 11 vertical). Writes to any other address change nothing.
- R3: A line lasts (period with bits 1:0 cleared) + 8 cycles. The horizontal count is zero on the first cycle of the line, and line_stb is high on exactly that cycle.
- R4: The horizontal sync is active for the first (sync width + 8) cycles of each line.
- R5: The horizontal border window covers counts from (start with bit 0 cleared) + 12 up to, but not including, (end with bit 0 cleared) + 12. The horizontal display window uses the same rule with an offset of 18.
- R6: A frame has vertical period + 1 lines, and the line count advances on each horizontal wrap. Vertical sync is active on lines 0 through the vertical sync value. The vertical border window covers lines [start+1, end+1), and the vertical display window covers lines [start+1, end+1) of its own values.
- R7: display_en is high only when both axes are inside their display windows. border_en is high when both axes are inside their border windows and display_en is low.
- R8: frame_stb is high for one cycle, on the first cycle of line 0 of each frame.
- R9: In the control word, bit 12 enables output, bit 16 inverts hsync and bit 18 inverts vsync. These take effect on the next cycle. While bit 12 is clear, both counters are held at zero, each sync sits at its inactive level (equal to its invert bit), and the windows and strobes are low.
- R10: While output is enabled, a timing write changes nothing until the first cycle of the next frame, and from then on it applies. While output is disabled, a timing write applies from the cycle after next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW (19) | Write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| border_en | output | 1 | Border colour window, outside the display window |
| display_en | output | 1 | Active display window |
| line_stb | output | 1 | First cycle of each line |
| frame_stb | output | 1 | First cycle of each frame |

## Verification
The assertions check, on every cycle, the relations that hold whatever the programmed mode. Display and border are never high together. A frame strobe always falls on a line strobe. Strobes last exactly one cycle. Both syncs are active at the start of a line and of a frame. Everything is quiet while output is disabled. The working timing set changes only at a frame boundary. The exact cycle positions of the sync ends and of the window edges can only be shown by the bench scenarios. So can the masking of the low bits, the deferral of writes made mid-frame, and the handling of unused addresses. The bench compares every output against its own model of the raster on every cycle, and it also measures line lengths directly.

// File: rtl/rtg_pkg.sv
// Package: shared write-map addresses and control-word bit positions for
// the raster timing generator. Assumes a 4-bit register address space.
package rtg_pkg;
    localparam int ADDR_W      = 4;
    localparam int N_AXIS_REGS = 6;      // period, sync, bstart, bend, dstart, dend

    // Index of each timing value inside an axis set
    localparam int IX_PERIOD = 0;
    localparam int IX_SYNC   = 1;
    localparam int IX_BSTART = 2;
    localparam int IX_BEND   = 3;
    localparam int IX_DSTART = 4;
    localparam int IX_DEND   = 5;

    // Base addresses of the two axis sets and the control word
    localparam logic [ADDR_W-1:0] BASE_H = 4'd0;
    localparam logic [ADDR_W-1:0] BASE_V = 4'd8;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd15;

    // Control word bit positions
    localparam int BIT_ENABLE = 12;
    localparam int BIT_HINV   = 16;
    localparam int BIT_VINV   = 18;
endpackage

// File: rtl/rtg_regs.sv
// Module: rtg_regs
// Holds the shadow and working copies of both axis timing sets plus the
// control word. Shadow copies take bus writes; the working copies load
// from the shadows whenever load_act is high. The control word is applied
// directly. Assumes DW covers the highest control bit and both field widths.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              load_act,
    output logic [HW-1:0]     h_act [N_AXIS_REGS],
    output logic [VW-1:0]     v_act [N_AXIS_REGS],
    output logic              ctrl_en,
    output logic              hs_inv,
    output logic              vs_inv
);
    logic [HW-1:0] h_sh [N_AXIS_REGS];
    logic [VW-1:0] v_sh [N_AXIS_REGS];

    // Shadow copies: capture bus writes at their decoded addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_AXIS_REGS; i++) begin
                h_sh[i] <= '0;
                v_sh[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_AXIS_REGS; i++) begin
                if (wr_addr == BASE_H + ADDR_W'(i)) h_sh[i] <= wr_data[HW-1:0];
                if (wr_addr == BASE_V + ADDR_W'(i)) v_sh[i] <= wr_data[VW-1:0];
            end
        end
    end

    // Working copies: follow the shadows only at a load point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_AXIS_REGS; i++) begin
                h_act[i] <= '0;
                v_act[i] <= '0;
            end
        end else if (load_act) begin
            for (int i = 0; i < N_AXIS_REGS; i++) begin
                h_act[i] <= h_sh[i];
                v_act[i] <= v_sh[i];
            end
        end
    end

    // Control word: enable and sync polarities, applied at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            hs_inv  <= 1'b0;
            vs_inv  <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl_en <= wr_data[BIT_ENABLE];
            hs_inv  <= wr_data[BIT_HINV];
            vs_inv  <= wr_data[BIT_VINV];
        end
    end
endmodule

// File: rtl/rtg_axis.sv
// Module: rtg_axis
// One axis of the raster: a position counter that is zero at the sync
// leading edge, wraps after the programmed period, and decodes the sync,
// border and display windows from the working timing set. Parameters give
// the fixed offsets and the low bits ignored in each value. Assumes the
// working set only changes while the counter is zero.
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int W           = 12,
    parameter int PER_LOWBITS = 2,    // period bits forced to zero
    parameter int PER_ADD     = 8,    // period value + PER_ADD = length
    parameter int SYNC_ADD    = 8,
    parameter int WIN_LOWBITS = 1,    // window bits forced to zero
    parameter int BORDER_ADD  = 12,
    parameter int DISP_ADD    = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] cfg [N_AXIS_REGS],
    output logic         at_zero,
    output logic         wrap,
    output logic         sync_act,
    output logic         border_win,
    output logic         disp_win
);
    localparam int CNT_W = W + 1;
    localparam int CW    = W + 2;
    localparam logic [CW-1:0] PER_LOW = CW'((1 << PER_LOWBITS) - 1);
    localparam logic [CW-1:0] WIN_LOW = CW'((1 << WIN_LOWBITS) - 1);

    logic [CNT_W-1:0] cnt;
    logic [CW-1:0]    cnt_x, last, sync_end;
    logic [CW-1:0]    b_lo, b_hi, d_lo, d_hi;

    // Effective compare points measured from the sync edge
    always_comb begin
        cnt_x    = CW'(cnt);
        last     = (CW'(cfg[IX_PERIOD]) & ~PER_LOW) + CW'(PER_ADD - 1);
        sync_end = CW'(cfg[IX_SYNC]) + CW'(SYNC_ADD);
        b_lo     = (CW'(cfg[IX_BSTART]) & ~WIN_LOW) + CW'(BORDER_ADD);
        b_hi     = (CW'(cfg[IX_BEND])   & ~WIN_LOW) + CW'(BORDER_ADD);
        d_lo     = (CW'(cfg[IX_DSTART]) & ~WIN_LOW) + CW'(DISP_ADD);
        d_hi     = (CW'(cfg[IX_DEND])   & ~WIN_LOW) + CW'(DISP_ADD);
    end

    // Window and wrap decode of the current position
    always_comb begin
        at_zero    = (cnt == '0);
        wrap       = run && step && (cnt_x >= last);
        sync_act   = cnt_x < sync_end;
        border_win = (cnt_x >= b_lo) && (cnt_x < b_hi);
        disp_win   = (cnt_x >= d_lo) && (cnt_x < d_hi);
    end

    // Position counter: held at zero when stopped, wraps at period end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Module: raster_timing_gen (top)
// Programmable sync-referenced raster timing. A horizontal axis steps on
// every cycle and a vertical axis steps on each horizontal wrap. Timing
// writes are staged and applied at a frame boundary. The outputs are
// decoded from registered counters and gated by the enable bit.
// Assumes a single clock domain with one pixel per cycle.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              border_en,
    output logic              display_en,
    output logic              line_stb,
    output logic              frame_stb
);
    logic [HW-1:0] h_act [N_AXIS_REGS];
    logic [VW-1:0] v_act [N_AXIS_REGS];
    logic ctrl_en, hs_inv, vs_inv;
    logic frame_wrap, load_act;

    logic [1:0] ax_zero, ax_wrap, ax_sync, ax_border, ax_disp;

    assign load_act = !ctrl_en || frame_wrap;

    rtg_regs #(.HW(HW), .VW(VW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_act (load_act),
        .h_act    (h_act),
        .v_act    (v_act),
        .ctrl_en  (ctrl_en),
        .hs_inv   (hs_inv),
        .vs_inv   (vs_inv)
    );

    // Axis 0 is horizontal (offset, even-valued), axis 1 is vertical (minus one)
    generate
        for (genvar a = 0; a < 2; a++) begin : g_axis
            if (a == 0) begin : g_h
                rtg_axis #(
                    .W(HW), .PER_LOWBITS(2), .PER_ADD(8), .SYNC_ADD(8),
                    .WIN_LOWBITS(1), .BORDER_ADD(12), .DISP_ADD(18)
                ) u_ax (
                    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .step(1'b1),
                    .cfg(h_act), .at_zero(ax_zero[a]), .wrap(ax_wrap[a]),
                    .sync_act(ax_sync[a]), .border_win(ax_border[a]),
                    .disp_win(ax_disp[a])
                );
            end else begin : g_v
                rtg_axis #(
                    .W(VW), .PER_LOWBITS(0), .PER_ADD(1), .SYNC_ADD(1),
                    .WIN_LOWBITS(0), .BORDER_ADD(1), .DISP_ADD(1)
                ) u_ax (
                    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .step(ax_wrap[0]),
                    .cfg(v_act), .at_zero(ax_zero[a]), .wrap(ax_wrap[a]),
                    .sync_act(ax_sync[a]), .border_win(ax_border[a]),
                    .disp_win(ax_disp[a])
                );
            end
        end
    endgenerate

    assign frame_wrap = ax_wrap[1];

    // Output decode: enable gating, polarity and window combination
    always_comb begin
        display_en = ctrl_en && (&ax_disp);
        border_en  = ctrl_en && (&ax_border) && !(&ax_disp);
        hsync      = hs_inv ^ (ctrl_en && ax_sync[0]);
        vsync      = vs_inv ^ (ctrl_en && ax_sync[1]);
        line_stb   = ctrl_en && ax_zero[0];
        frame_stb  = ctrl_en && ax_zero[0] && ax_zero[1];
    end
endmodule

// File: rtl/rtg_checker.sv
// Module: rtg_checker
// Cycle-level properties of the raster timing generator, bound to the top.
// Assumes the minimum line length of 8 cycles that the encoding implies.
module rtg_checker #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_en,
    input logic          hs_inv,
    input logic          vs_inv,
    input logic          frame_wrap,
    input logic [HW-1:0] h_period,
    input logic [VW-1:0] v_period,
    input logic          hsync,
    input logic          vsync,
    input logic          border_en,
    input logic          display_en,
    input logic          line_stb,
    input logic          frame_stb
);
    // R7: border and display windows never overlap
    a_r7_exclusive_windows: assert property (@(posedge clk) disable iff (!rst_n)
        !(border_en && display_en));

    // R8: a frame start is always also a line start
    a_r8_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> line_stb);

    // R3: the line strobe lasts a single cycle
    a_r3_single_line_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb |=> !line_stb);

    // R4: hsync is active on the first cycle of every line
    a_r4_hsync_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb |-> (hsync != hs_inv));

    // R6: vsync is active on the first cycle of every frame
    a_r6_vsync_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (vsync != vs_inv));

    // R9: disabled output is quiet with syncs at their inactive level
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (!display_en && !border_en && !line_stb && !frame_stb
                      && hsync == hs_inv && vsync == vs_inv));

    // R10: working timing set holds steady inside a running frame
    a_r10_midframe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && $past(ctrl_en) && !$past(frame_wrap))
        |-> ($stable(h_period) && $stable(v_period)));
endmodule

bind raster_timing_gen rtg_checker #(.HW(HW), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .hs_inv     (hs_inv),
    .vs_inv     (vs_inv),
    .frame_wrap (frame_wrap),
    .h_period   (h_act[0]),
    .v_period   (v_act[0]),
    .hsync      (hsync),
    .vsync      (vsync),
    .border_en  (border_en),
    .display_en (display_en),
    .line_stb   (line_stb),
    .frame_stb  (frame_stb)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int DW = 19;
    localparam int HMASK = (1 << HW) - 1;
    localparam int VMASK = (1 << VW) - 1;
    localparam int EN  = 1 << 12;
    localparam int HIV = 1 << 16;
    localparam int VIV = 1 << 18;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [3:0] wr_addr = 0;
    logic [DW-1:0] wr_data = 0;
    logic hsync, vsync, border_en, display_en, line_stb, frame_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    raster_timing_gen #(.HW(HW), .VW(VW), .DW(DW)) u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
        .border_en(border_en), .display_en(display_en),
        .line_stb(line_stb), .frame_stb(frame_stb)
    );

    // Reference model state
    int mh, mv;
    int hs [6], vs [6], ha [6], va [6];
    bit men, mhi, mvi;

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit in_win(int p, int lo, int hi);
        return (p >= lo) && (p < hi);
    endfunction

    // Advance the model across one clock edge using pre-edge state
    task automatic model_edge();
        int hl, vl;
        bit hw, fw;
        hl = (ha[0] & ~3) + 7;
        vl = va[0];
        hw = men && (mh >= hl);
        fw = hw && (mv >= vl);
        if (!men || fw) begin
            for (int i = 0; i < 6; i++) begin ha[i] = hs[i]; va[i] = vs[i]; end
        end
        if (!men) begin mh = 0; mv = 0; end
        else begin
            mh = hw ? 0 : mh + 1;
            if (hw) mv = fw ? 0 : mv + 1;
        end
        if (rst_n == 0) begin
            for (int i = 0; i < 6; i++) begin hs[i] = 0; vs[i] = 0; ha[i] = 0; va[i] = 0; end
            men = 0; mhi = 0; mvi = 0; mh = 0; mv = 0;
        end else if (wr_en) begin
            if (wr_addr <= 5) hs[wr_addr] = int'(wr_data) & HMASK;
            else if (wr_addr >= 8 && wr_addr <= 13) vs[wr_addr-8] = int'(wr_data) & VMASK;
            else if (wr_addr == 15) begin
                men = wr_data[12]; mhi = wr_data[16]; mvi = wr_data[18];
            end
        end
    endtask

    task automatic compare_all();
        bit hd, vd, hb, vb, eh, ev;
        hd = in_win(mh, (ha[4] & ~1) + 18, (ha[5] & ~1) + 18);
        hb = in_win(mh, (ha[2] & ~1) + 12, (ha[3] & ~1) + 12);
        vd = in_win(mv, va[4] + 1, va[5] + 1);
        vb = in_win(mv, va[2] + 1, va[3] + 1);
        eh = men && (mh < ha[1] + 8);
        ev = men && (mv < va[1] + 1);
        chk("R4", "hsync", hsync, mhi ^ eh);
        chk("R6", "vsync", vsync, mvi ^ ev);
        chk("R7", "display_en", display_en, men && hd && vd);
        chk("R5", "border_en", border_en, men && hb && vb && !(hd && vd));
        chk("R3", "line_stb", line_stb, men && mh == 0);
        chk("R8", "frame_stb", frame_stb, men && mh == 0 && mv == 0);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic wr(int addr, int data);
        wr_en = 1; wr_addr = 4'(addr); wr_data = DW'(data);
        cyc();
        wr_en = 0;
    endtask

    // Cycles from one line strobe to the next
    task automatic line_len(output int n);
        int guard = 0;
        while (!line_stb && guard < 10000) begin cyc(); guard++; end
        n = 0;
        do begin cyc(); n++; end while (!line_stb && n < 10000);
    endtask

    task automatic wait_frame();
        int guard = 0;
        while (!frame_stb && guard < 50000) begin cyc(); guard++; end
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        rst_n = 0;
        cyc(); cyc();
        rst_n = 1;
        #1;
        // R1: everything idle out of reset
        chk("R1", "hsync", hsync, 1'b0);
        chk("R1", "vsync", vsync, 1'b0);
        chk("R1", "display_en", display_en, 1'b0);
        chk("R1", "line_stb", line_stb, 1'b0);
        cyc();

        // Directed mode: period 17 (masked to 16, line 24), odd window values (R2, R5)
        wr(0, 17); wr(1, 0); wr(2, 1); wr(3, 10); wr(4, 0); wr(5, 3);
        wr(8, 5); wr(9, 0); wr(10, 1); wr(11, 4); wr(12, 2); wr(13, 3);
        wr(15, EN);
        line_len(n);
        chk_int("R3", "line length with period 17", n, 24);

        // R2: write to an unused address and high data bits change nothing
        wr(6, 4); wr(7, 100); wr(14, 9);
        wait_frame();
        cyc();
        line_len(n);
        chk_int("R2", "line length after unused-address writes", n, 24);

        // R10: mid-frame period change deferred to the next frame
        line_len(n);
        wr(0, 20);
        line_len(n);
        chk_int("R10", "line length before frame boundary", n, 24);
        wait_frame();
        cyc();
        line_len(n);
        chk_int("R10", "line length after frame boundary", n, 28);

        // R9: polarity inversion and disable
        wr(15, EN | HIV | VIV);
        repeat (60) cyc();
        wr(15, 0);
        chk("R9", "hsync when disabled", hsync, 1'b0);
        chk("R9", "display_en when disabled", display_en, 1'b0);
        wr(15, HIV);
        repeat (5) cyc();
        chk("R9", "hsync idle inverted", hsync, 1'b1);
        chk("R9", "line_stb idle", line_stb, 1'b0);
        // R10: while disabled, a timing write applies at once
        wr(0, 0);
        wr(15, EN);
        line_len(n);
        chk_int("R10", "line length written while disabled", n, 8);

        // Constrained random modes, mid-frame writes and control changes
        for (int r = 0; r < 24; r++) begin
            int rounds;
            wr(0, $urandom % 36);
            wr(1, $urandom % 10);
            wr(2, $urandom % 20); wr(3, $urandom % 30);
            wr(4, $urandom % 24); wr(5, $urandom % 34);
            wr(8, $urandom % 7);  wr(9, $urandom % 3);
            wr(10, $urandom % 4); wr(11, $urandom % 8);
            wr(12, $urandom % 4); wr(13, $urandom % 8);
            case ($urandom % 4)
                0: wr(15, EN);
                1: wr(15, EN | HIV);
                2: wr(15, EN | VIV);
                default: wr(15, ($urandom % 2) ? 0 : EN | HIV | VIV);
            endcase
            rounds = 100 + ($urandom % 400);
            for (int c = 0; c < rounds; c++) begin
                if (($urandom % 64) == 0) wr($urandom % 16, $urandom);
                else cyc();
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule